// File: doc/BRIEF.md
# Fifth-Order Sinc Decimator

This block turns a one-bit delta-sigma bitstream into signed multi-bit samples at a lower rate. It is a fifth-order cascaded integrator-comb filter. Five integrators run at the input rate, and only on cycles that carry a valid bit. A decimation counter picks one integrator value in every R. Five comb stages then difference those values at the low rate. Each incoming bit is worth +1 (bit high) or -1 (bit low).

The ratio R is chosen from a small power-of-two set by a select input. The block samples the select only while it is being cleared, so a new ratio needs a clear. A synchronous clear empties every integrator, comb delay and counter, which lets several converters restart in step after a shared event. After any clear the output strobe stays low while the comb delays fill. The samples can feed a later low-pass decimation stage or be used directly.

Top module: `cic5_decim`

## Requirements
- R1: While and right after reset, `smp_valid` is low.
- R2: A constant input of all ones settles to +R^5 and a constant input of all zeros settles to -R^5.
- R3: The ratio is R = 2^(LOG2_MIN + sel). With the defaults, select codes 0, 1, 2, 3 give R = 8, 16, 32, 64. Once the filter is filled, exactly one output comes out for every R accepted input bits.
- R4: After a clear, the first five decimation periods produce no output. The first `smp_valid` pulse follows the 6R-th accepted input bit.
- R5: A cycle with `mod_valid` low changes no filter state and counts toward nothing. Inputs with gaps give the same values at the same accepted-input positions as a gap-free stream.
- R6: A `sync_clr` pulse drops `smp_valid` in the next cycle and restarts filtering and warm-up from zero. A bit presented in the clear cycle is discarded, and the select value present in that cycle becomes the active ratio.
- R7: Changing `ratio_sel` without a clear has no effect on output spacing or values.
- R8: A steady alternating 1,0 pattern settles to exactly 0 for any R.
- R9: A repeating 1,1,1,0 pattern settles to exactly R^5/2 for any R that is a multiple of 4.
- R10: The output is signed two's complement, 2 + 5*log2(Rmax) bits wide (32 with the defaults), so +R^5 at the largest ratio is shown without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; samples `ratio_sel` |
| sync_clr | input | 1 | Synchronous filter clear; samples `ratio_sel` |
| ratio_sel | input | SEL_W (2) | Decimation ratio select, R = 2^(LOG2_MIN+sel) |
| mod_bit | input | 1 | Modulator bit, 1 means +1 and 0 means -1 |
| mod_valid | input | 1 | Qualifies `mod_bit` for this cycle |
| smp_out | output | OUT_W (32) | Signed decimated sample |
| smp_valid | output | 1 | One-cycle strobe for `smp_out` |

## Verification
A sample is due in the clock cycle right after the edge that accepts the last bit of its period. The first sample after a clear follows the 6R-th accepted bit, and each later one follows R more accepted bits. The bench never counts cycles. A monitor runs a short delay after each rising edge and counts the bits accepted at that edge. Whenever `smp_valid` is high, it records the accepted-bit position together with the value. Each scenario then compares the first position, the spacing and the settled value with numbers computed from R. Because the checks use positions rather than cycle counts, they work unchanged when the input has gaps.

// File: rtl/cic5_pkg.sv
package cic5_pkg;
  localparam int CIC_ORDER = 5;

  // Weight of one modulator bit: +1 for a high bit, -1 for a low bit.
  function automatic logic signed [1:0] bit_to_step(input logic b);
    return b ? 2'sb01 : 2'sb11;
  endfunction

  // Decimation period for a select code.
  function automatic int unsigned period_of(input int unsigned log2_min,
                                            input int unsigned sel);
    return 32'd1 << (log2_min + sel);
  endfunction

  // Output width that carries +/- Rmax^5.
  function automatic int unsigned acc_width(input int unsigned log2_max);
    return 2 + CIC_ORDER * log2_max;
  endfunction
endpackage

// File: rtl/cic5_ctrl.sv
module cic5_ctrl
  import cic5_pkg::*;
#(
  parameter int LOG2_MIN = 3,
  parameter int SEL_W    = 2,
  localparam int LOG2_MAX = LOG2_MIN + (1 << SEL_W) - 1,
  localparam int CNT_W    = LOG2_MAX,
  localparam int WU_W     = $clog2(CIC_ORDER + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [SEL_W-1:0] ratio_sel,
  input  logic             in_valid,
  output logic             tick,
  output logic             emit
);
  logic [SEL_W-1:0] act_sel;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last_idx;
  logic [WU_W-1:0]  wu;
  logic             warm_done;

  always_comb begin
    last_idx  = CNT_W'(period_of(LOG2_MIN, 32'(act_sel)) - 1);
    warm_done = (wu == WU_W'(CIC_ORDER));
    tick      = in_valid && (cnt == last_idx);
    emit      = tick && warm_done;
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt     <= '0;
      wu      <= '0;
      act_sel <= ratio_sel;
    end else if (in_valid) begin
      cnt <= tick ? '0 : cnt + 1'b1;
      if (tick && !warm_done) wu <= wu + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= last_idx); // R3
  AST_RATIO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> $stable(act_sel)); // R7
  AST_WARM_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (wu >= $past(wu))); // R4
endmodule

// File: rtl/cic5_integ.sv
module cic5_integ #(
  parameter int W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                en,
  input  logic signed [W-1:0] din,
  output logic signed [W-1:0] acc
);
  // Wrap-around two's-complement accumulation.
  always_ff @(posedge clk) begin
    if (clr)     acc <= '0;
    else if (en) acc <= acc + din;
  end

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(acc)); // R5
endmodule

// File: rtl/cic5_comb.sv
module cic5_comb
  import cic5_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                tick,
  input  logic                emit,
  input  logic signed [W-1:0] din,
  output logic signed [W-1:0] dout,
  output logic                dvalid
);
  genvar k;
  for (k = 0; k < CIC_ORDER; k++) begin : g_cmb
    logic signed [W-1:0] src;
    logic signed [W-1:0] dly;
    logic signed [W-1:0] diff;
    if (k == 0) begin : g_first
      assign src = din;
    end else begin : g_next
      assign src = g_cmb[k-1].diff;
    end
    assign diff = src - dly;
    always_ff @(posedge clk) begin
      if (clr)       dly <= '0;
      else if (tick) dly <= src;
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      dvalid <= 1'b0;
      dout   <= '0;
    end else begin
      dvalid <= emit;
      if (emit) dout <= g_cmb[CIC_ORDER-1].diff;
    end
  end

  AST_CLR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !dvalid); // R6
  AST_EMIT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    dvalid |-> $past(tick)); // R3
endmodule

// File: rtl/cic5_decim.sv
module cic5_decim
  import cic5_pkg::*;
#(
  parameter int LOG2_MIN = 3,
  parameter int SEL_W    = 2,
  localparam int LOG2_MAX = LOG2_MIN + (1 << SEL_W) - 1,
  localparam int OUT_W    = 2 + CIC_ORDER * LOG2_MAX
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sync_clr,
  input  logic [SEL_W-1:0]        ratio_sel,
  input  logic                    mod_bit,
  input  logic                    mod_valid,
  output logic signed [OUT_W-1:0] smp_out,
  output logic                    smp_valid
);
  logic                    clr_all;
  logic                    evt_tick;
  logic                    evt_emit;
  logic signed [1:0]       step;
  logic signed [OUT_W-1:0] step_ext;
  logic signed [OUT_W-1:0] int_last;

  assign clr_all  = !rst_n || sync_clr;
  assign step     = bit_to_step(mod_bit);
  assign step_ext = {{(OUT_W-2){step[1]}}, step};

  cic5_ctrl #(.LOG2_MIN(LOG2_MIN), .SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clr(clr_all), .ratio_sel(ratio_sel),
    .in_valid(mod_valid), .tick(evt_tick), .emit(evt_emit)
  );

  genvar k;
  for (k = 0; k < CIC_ORDER; k++) begin : g_int
    logic signed [OUT_W-1:0] src;
    logic signed [OUT_W-1:0] acc;
    if (k == 0) begin : g_first
      assign src = step_ext;
    end else begin : g_next
      assign src = g_int[k-1].acc;
    end
    cic5_integ #(.W(OUT_W)) u_int (
      .clk(clk), .rst_n(rst_n), .clr(clr_all), .en(mod_valid),
      .din(src), .acc(acc)
    );
  end
  assign int_last = g_int[CIC_ORDER-1].acc;

  cic5_comb #(.W(OUT_W)) u_comb (
    .clk(clk), .rst_n(rst_n), .clr(clr_all), .tick(evt_tick),
    .emit(evt_emit), .din(int_last), .dout(smp_out), .dvalid(smp_valid)
  );

  AST_OUT_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> $past(mod_valid && !sync_clr)); // R5
endmodule

// File: tb/cic5_decim_tb_top.sv
module cic5_decim_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, sync_clr, mod_bit, mod_valid;
  logic [1:0]  ratio_sel;
  logic signed [31:0] smp_out;
  logic        smp_valid;

  int    n_chk = 0, n_bad = 0;
  longint consumed, first_pos, last_pos, last_gap, nout, last_val;
  logic  took;
  bit    done = 0;

  always #4 clk = ~clk;

  cic5_decim dut_i (
    .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .ratio_sel(ratio_sel),
    .mod_bit(mod_bit), .mod_valid(mod_valid), .smp_out(smp_out),
    .smp_valid(smp_valid)
  );

  // Monitor: counts accepted bits per edge, logs output position and value.
  always @(posedge clk) begin
    took = mod_valid && !sync_clr && rst_n;
    #2;
    if (took) consumed++;
    if (smp_valid) begin
      if (nout == 0) first_pos = consumed;
      else last_gap = consumed - last_pos;
      last_pos = consumed;
      last_val = longint'(smp_out);
      nout++;
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic mon_clear();
    consumed = 0; nout = 0; first_pos = -1; last_pos = 0; last_gap = 0;
  endtask

  function automatic longint pow5(longint r);
    return r * r * r * r * r;
  endfunction

  function automatic logic pat_bit(int pat, int i);
    case (pat)
      0: return 1'b0;
      1: return 1'b1;
      2: return (i % 2) == 0;
      default: return (i % 4) != 3;
    endcase
  endfunction

  // Clear with a valid zero bit in the same cycle; that bit must be dropped.
  task automatic do_clr(int sel);
    @(negedge clk);
    sync_clr = 1; ratio_sel = 2'(sel); mod_valid = 1; mod_bit = 0;
    @(negedge clk);
    sync_clr = 0; mod_valid = 0;
    chk("R6", "valid after clear", longint'(smp_valid), 0);
    mon_clear();
  endtask

  task automatic feed(int n, int pat, int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      mod_valid = 1; mod_bit = pat_bit(pat, i);
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        mod_valid = 0;
      end
    end
    @(negedge clk);
    mod_valid = 0;
  endtask

  task automatic t_reset();
    rst_n = 0; sync_clr = 0; mod_valid = 0; mod_bit = 0; ratio_sel = 0;
    mon_clear();
    repeat (3) @(negedge clk);
    chk("R1", "valid in reset", longint'(smp_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "valid after reset", longint'(smp_valid), 0);
  endtask

  task automatic t_dc(int sel, int pat, int gap, string req);
    longint r = longint'(8) << sel;
    do_clr(sel);
    feed(int'(8 * r), pat, gap);
    chk("R4", "first output position", first_pos, 6 * r);
    chk("R3", "output count", nout, 3);
    chk("R3", "output spacing", last_gap, r);
    chk(req, "settled value", last_val, (pat == 1) ? pow5(r) : -pow5(r));
  endtask

  task automatic t_nochange();
    do_clr(0);
    @(negedge clk); ratio_sel = 2'd3;
    feed(64, 1, 0);
    chk("R7", "first position after sel change", first_pos, 48);
    chk("R7", "spacing after sel change", last_gap, 8);
    chk("R7", "value after sel change", last_val, 32768);
  endtask

  task automatic t_clr_mid();
    do_clr(2);
    feed(7 * 32, 1, 0);
    chk("R6", "outputs before mid clear", nout, 2);
    do_clr(0);
    feed(64, 0, 0);
    chk("R6", "first position after mid clear", first_pos, 48);
    chk("R6", "value after mid clear", last_val, -32768);
  endtask

  task automatic t_patterns();
    do_clr(2);
    feed(8 * 32, 2, 0);
    chk("R8", "alternating value", last_val, 0);
    do_clr(1);
    feed(8 * 16, 3, 0);
    chk("R9", "3:1 duty value", last_val, pow5(16) / 2);
    do_clr(3);
    feed(8 * 64, 3, 0);
    chk("R9", "3:1 duty value at R=64", last_val, pow5(64) / 2);
  endtask

  initial begin
    t_reset();
    t_dc(0, 1, 0, "R2");
    t_dc(1, 0, 0, "R2");
    t_dc(2, 1, 0, "R2");
    t_dc(3, 1, 0, "R10");
    t_dc(3, 0, 0, "R10");
    t_dc(0, 1, 2, "R5");
    t_dc(1, 0, 1, "R5");
    t_nochange();
    t_clr_mid();
    t_patterns();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule